// File: doc/BRIEF.md
# Interlaced Video Timing Generator

This block produces the raster timing for standard-definition interlaced composite video at one pixel per clock. A horizontal state machine walks each line through active pixels, front porch, sync and back porch. A vertical state machine walks each field through active lines, front porch, sync lines and back porch. An interlaced frame holds two fields. The odd field and the even field each have their own vertical segment lengths. The block adds the extra line that an odd frame line count needs to one of the two fields. It shifts the vertical sync of the second field of each frame by about half a line. A software-chosen bit selects which field comes first.

All configuration arrives on plain input ports. It is captured while reset is held and again on the last pixel of every frame, so each frame runs from a single consistent set of values. Typical settings are as follows. For the 525-line standard: 720/14/64/60 pixels per line and, per field, 240 active lines, odd field first. For the 625-line standard: 720/20/64/60 pixels, 288 active lines, even field first. In both cases the field shift is half the line length plus one pixel. In progressive mode the fields collapse into one repeating field that uses the odd set, with no extra line and no shift.

State machines. Horizontal: `H_ACT -> H_FRONT -> H_SYNC -> H_BACK -> H_ACT`. Each transition is taken when the segment counter reaches the programmed length of the current segment. `H_BACK -> H_ACT` is the line end. Vertical: `V_ACT -> V_FRONT -> V_SYNC -> V_BACK -> V_ACT`. These advance only at line ends. `V_BACK -> V_ACT` is the field end, and it is the frame end on the second field (or on every field when progressive). Synchronous reset puts both machines in their first state with their counters at zero.

Top module: `ilt_timing_gen`

## Requirements
- R1: Each line is made of `cfg_h_active`, `cfg_h_front`, `cfg_h_sync` and `cfg_h_back` pixels in that order, each length at least 1. `pix_x` counts from 0 at the first active pixel up to the line total minus 1, then wraps. `hsync` is high, active-high, exactly during the sync pixels.
- R2: Each field is made of its active lines, front porch lines, sync lines and back porch lines in that order, each at least 1. `line_y` counts from 0 at the first active line of the field and returns to 0 at the next field.
- R3: `active_video` is high exactly when both the pixel and the line lie in their active segments. Neither `hsync` nor `vsync` is ever high while it is.
- R4: In interlaced mode the frame gets one extra line. If the odd field comes first, the extra line is added to the even field's front porch. Otherwise it is added to the odd field's back porch. Progressive mode adds no line.
- R5: `field_id` is 1 for the odd field and 0 for the even field. Its reset value is the configured first field: `cfg_odd_first` when `cfg_interlace` is 1, otherwise 1. In interlaced mode it changes at every field end. In progressive mode it stays 1 and the odd set is used.
- R6: In the second field of an interlaced frame, `vsync` is shifted by d = floor(line total / 2) + `cfg_half_extra` pixels. It rises at `pix_x` = d of the first sync line and falls at `pix_x` = d of the line after the last sync line. In the first field, and in progressive mode, `vsync` covers whole sync lines.
- R7: Configuration is captured while reset is low and on the last pixel of each frame. A change at any other time has no effect on the outputs until the next frame begins.
- R8: While reset is held, `pix_x` and `line_y` are 0, `hsync` and `vsync` are 0, and `field_id` shows the configured first field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while low |
| cfg_h_active | input | HW | Active pixels per line |
| cfg_h_front | input | HW | Horizontal front porch pixels |
| cfg_h_sync | input | HW | Horizontal sync pixels |
| cfg_h_back | input | HW | Horizontal back porch pixels |
| cfg_odd_v_active | input | VW | Odd field active lines |
| cfg_odd_v_front | input | VW | Odd field front porch lines |
| cfg_odd_v_sync | input | VW | Odd field sync lines |
| cfg_odd_v_back | input | VW | Odd field back porch lines |
| cfg_even_v_active | input | VW | Even field active lines |
| cfg_even_v_front | input | VW | Even field front porch lines |
| cfg_even_v_sync | input | VW | Even field sync lines |
| cfg_even_v_back | input | VW | Even field back porch lines |
| cfg_interlace | input | 1 | 1 = two fields per frame, 0 = progressive |
| cfg_odd_first | input | 1 | 1 = odd field opens the frame |
| cfg_half_extra | input | 1 | Adds one pixel to the half-line vsync shift |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| active_video | output | 1 | Pixel lies in the active picture |
| field_id | output | 1 | 1 = odd field, 0 = even field |
| pix_x | output | HW | Pixel index within the line |
| line_y | output | VW | Line index within the field |

## Verification
The riskiest overlap is the frame boundary. On that one pixel the configuration reload, the field toggle (or its reset to the new first field), and the switch between the shifted and the unshifted vsync all take effect together. In alternating phases the bench changes every configuration input exactly on the last pixel of the frame, including the interlace and field-order bits. It then compares every output on every following pixel against a position-based model that takes the new values from the first pixel of the next frame. In the other phases, random changes land mid-frame and must leave the running frame untouched.

// File: rtl/ilt_pkg.sv
package ilt_pkg;
    typedef enum logic [1:0] {
        H_ACT   = 2'd0,
        H_FRONT = 2'd1,
        H_SYNC  = 2'd2,
        H_BACK  = 2'd3
    } hstate_t;

    typedef enum logic [1:0] {
        V_ACT   = 2'd0,
        V_FRONT = 2'd1,
        V_SYNC  = 2'd2,
        V_BACK  = 2'd3
    } vstate_t;
endpackage

// File: rtl/ilt_hcount.sv
module ilt_hcount
    import ilt_pkg::*;
#(
    parameter int HW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] len_act,
    input  logic [HW-1:0] len_front,
    input  logic [HW-1:0] len_sync,
    input  logic [HW-1:0] len_back,
    output hstate_t       state,
    output logic [HW-1:0] hpos,
    output logic          line_end
);
    logic [HW-1:0] seg;
    logic [HW-1:0] seg_len;
    hstate_t       nxt;
    logic          seg_done;

    // segment length and successor of the current horizontal state
    always_comb begin
        seg_len = len_act;
        nxt     = H_FRONT;
        unique case (state)
            H_ACT:   begin seg_len = len_act;   nxt = H_FRONT; end
            H_FRONT: begin seg_len = len_front; nxt = H_SYNC;  end
            H_SYNC:  begin seg_len = len_sync;  nxt = H_BACK;  end
            H_BACK:  begin seg_len = len_back;  nxt = H_ACT;   end
        endcase
        seg_done = (seg == seg_len - 1'b1);
        line_end = seg_done && (state == H_BACK);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= H_ACT;
            seg   <= '0;
            hpos  <= '0;
        end else begin
            hpos <= line_end ? '0 : hpos + 1'b1;
            if (seg_done) begin
                state <= nxt;
                seg   <= '0;
            end else begin
                seg <= seg + 1'b1;
            end
        end
    end

    AST_HPOS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |=> (hpos == '0)) else $error("hpos did not wrap"); // R1
    AST_HPOS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !line_end |=> (hpos == $past(hpos) + 1'b1)) else $error("hpos skipped"); // R1
endmodule

// File: rtl/ilt_vcount.sv
module ilt_vcount
    import ilt_pkg::*;
#(
    parameter int VW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_end,
    input  logic [VW-1:0] len_act,
    input  logic [VW-1:0] len_front,
    input  logic [VW-1:0] len_sync,
    input  logic [VW-1:0] len_back,
    input  logic          interlace,
    input  logic          first_field,
    input  logic          next_first,
    output vstate_t       state,
    output logic [VW-1:0] line_y,
    output logic          field_id,
    output logic          field_end,
    output logic          frame_end
);
    logic [VW-1:0] seg;
    logic [VW-1:0] seg_len;
    vstate_t       nxt;
    logic          seg_done;

    always_comb begin
        seg_len = len_act;
        nxt     = V_FRONT;
        unique case (state)
            V_ACT:   begin seg_len = len_act;   nxt = V_FRONT; end
            V_FRONT: begin seg_len = len_front; nxt = V_SYNC;  end
            V_SYNC:  begin seg_len = len_sync;  nxt = V_BACK;  end
            V_BACK:  begin seg_len = len_back;  nxt = V_ACT;   end
        endcase
        seg_done  = (seg == seg_len - 1'b1);
        field_end = line_end && seg_done && (state == V_BACK);
        frame_end = field_end && (!interlace || (field_id != first_field));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= V_ACT;
            seg      <= '0;
            line_y   <= '0;
            field_id <= next_first;
        end else if (line_end) begin
            line_y <= field_end ? '0 : line_y + 1'b1;
            if (seg_done) begin
                state <= nxt;
                seg   <= '0;
            end else begin
                seg <= seg + 1'b1;
            end
            if (frame_end)      field_id <= next_first;
            else if (field_end) field_id <= ~field_id;
        end
    end

    AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !field_end |=> $stable(field_id)) else $error("field changed mid-field"); // R5
    AST_FIELD_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (field_end && !frame_end) |=> (field_id != $past(field_id))) else $error("no field toggle"); // R5
    AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !line_end |=> $stable(line_y)) else $error("line index moved mid-line"); // R2
endmodule

// File: rtl/ilt_vsync_shift.sv
module ilt_vsync_shift #(
    parameter int HW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_sync,
    input  logic          shift_en,
    input  logic [HW-1:0] hpos,
    input  logic [HW-1:0] delay,
    output logic          vsync
);
    logic hold;

    // sampled one pixel before the shift point so it shows at pixel 'delay'
    always_ff @(posedge clk) begin
        if (!rst_n)                      hold <= 1'b0;
        else if (hpos == delay - 1'b1)   hold <= in_sync;
    end

    always_comb vsync = shift_en ? hold : in_sync;

    AST_VS_RISE_AT_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && $rose(vsync)) |-> (hpos == delay)) else $error("shifted vsync rose off-point"); // R6
    AST_VS_FALL_AT_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && $fell(vsync)) |-> (hpos == delay)) else $error("shifted vsync fell off-point"); // R6
endmodule

// File: rtl/ilt_timing_gen.sv
module ilt_timing_gen
    import ilt_pkg::*;
#(
    parameter int HW = 11,
    parameter int VW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] cfg_h_active,
    input  logic [HW-1:0] cfg_h_front,
    input  logic [HW-1:0] cfg_h_sync,
    input  logic [HW-1:0] cfg_h_back,
    input  logic [VW-1:0] cfg_odd_v_active,
    input  logic [VW-1:0] cfg_odd_v_front,
    input  logic [VW-1:0] cfg_odd_v_sync,
    input  logic [VW-1:0] cfg_odd_v_back,
    input  logic [VW-1:0] cfg_even_v_active,
    input  logic [VW-1:0] cfg_even_v_front,
    input  logic [VW-1:0] cfg_even_v_sync,
    input  logic [VW-1:0] cfg_even_v_back,
    input  logic          cfg_interlace,
    input  logic          cfg_odd_first,
    input  logic          cfg_half_extra,
    output logic          hsync,
    output logic          vsync,
    output logic          active_video,
    output logic          field_id,
    output logic [HW-1:0] pix_x,
    output logic [VW-1:0] line_y
);
    localparam int CFG_W = 4 * HW + 8 * VW + 3;

    // frame-stable copy of the configuration
    logic [HW-1:0] s_ha, s_hf, s_hs, s_hb;
    logic [VW-1:0] s_oa, s_of, s_os, s_ob;
    logic [VW-1:0] s_ea, s_ef, s_es, s_eb;
    logic          s_int, s_oddf, s_ext;

    hstate_t       hst;
    vstate_t       vst;
    logic          line_end, field_end, frame_end;
    logic          next_first;
    logic [HW-1:0] htotal, delay;
    logic [VW-1:0] odd_bp_eff, even_fp_eff;
    logic [VW-1:0] f_act, f_front, f_sync, f_back;
    logic          shift_en, in_sync;
    logic [CFG_W-1:0] shadow_bus;

    always_ff @(posedge clk) begin
        if (!rst_n || frame_end) begin
            s_ha <= cfg_h_active;      s_hf <= cfg_h_front;
            s_hs <= cfg_h_sync;        s_hb <= cfg_h_back;
            s_oa <= cfg_odd_v_active;  s_of <= cfg_odd_v_front;
            s_os <= cfg_odd_v_sync;    s_ob <= cfg_odd_v_back;
            s_ea <= cfg_even_v_active; s_ef <= cfg_even_v_front;
            s_es <= cfg_even_v_sync;   s_eb <= cfg_even_v_back;
            s_int  <= cfg_interlace;
            s_oddf <= cfg_odd_first;
            s_ext  <= cfg_half_extra;
        end
    end

    always_comb begin
        next_first  = cfg_interlace ? cfg_odd_first : 1'b1;
        htotal      = s_ha + s_hf + s_hs + s_hb;
        delay       = (htotal >> 1) + {{(HW-1){1'b0}}, s_ext};
        odd_bp_eff  = s_ob + {{(VW-1){1'b0}}, (s_int & ~s_oddf)};
        even_fp_eff = s_ef + {{(VW-1){1'b0}}, (s_int & s_oddf)};
        if (field_id) begin
            f_act = s_oa; f_front = s_of;        f_sync = s_os; f_back = odd_bp_eff;
        end else begin
            f_act = s_ea; f_front = even_fp_eff; f_sync = s_es; f_back = s_eb;
        end
        shift_en     = s_int && (field_id != s_oddf);
        in_sync      = (vst == V_SYNC);
        hsync        = (hst == H_SYNC);
        active_video = (hst == H_ACT) && (vst == V_ACT);
        shadow_bus   = {s_ha, s_hf, s_hs, s_hb, s_oa, s_of, s_os, s_ob,
                        s_ea, s_ef, s_es, s_eb, s_int, s_oddf, s_ext};
    end

    ilt_hcount #(.HW(HW)) u_h (
        .clk(clk), .rst_n(rst_n),
        .len_act(s_ha), .len_front(s_hf), .len_sync(s_hs), .len_back(s_hb),
        .state(hst), .hpos(pix_x), .line_end(line_end)
    );

    ilt_vcount #(.VW(VW)) u_v (
        .clk(clk), .rst_n(rst_n), .line_end(line_end),
        .len_act(f_act), .len_front(f_front), .len_sync(f_sync), .len_back(f_back),
        .interlace(s_int), .first_field(s_oddf), .next_first(next_first),
        .state(vst), .line_y(line_y), .field_id(field_id),
        .field_end(field_end), .frame_end(frame_end)
    );

    ilt_vsync_shift #(.HW(HW)) u_vs (
        .clk(clk), .rst_n(rst_n), .in_sync(in_sync), .shift_en(shift_en),
        .hpos(pix_x), .delay(delay), .vsync(vsync)
    );

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(shadow_bus)) else $error("config moved mid-frame"); // R7
    AST_ACTIVE_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
        active_video |-> (!hsync && !vsync)) else $error("sync inside picture"); // R3
endmodule

// File: tb/tb_ilt_timing_gen.sv
module tb_ilt_timing_gen;
    localparam int HW = 11;
    localparam int VW = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [HW-1:0] c_ha, c_hf, c_hs, c_hb;
    logic [VW-1:0] c_oa, c_of, c_os, c_ob, c_ea, c_ef, c_es, c_eb;
    logic          c_int, c_oddf, c_ext;
    logic          hsync, vsync, active_video, field_id;
    logic [HW-1:0] pix_x;
    logic [VW-1:0] line_y;

    ilt_timing_gen #(.HW(HW), .VW(VW)) dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_h_active(c_ha), .cfg_h_front(c_hf), .cfg_h_sync(c_hs), .cfg_h_back(c_hb),
        .cfg_odd_v_active(c_oa), .cfg_odd_v_front(c_of), .cfg_odd_v_sync(c_os), .cfg_odd_v_back(c_ob),
        .cfg_even_v_active(c_ea), .cfg_even_v_front(c_ef), .cfg_even_v_sync(c_es), .cfg_even_v_back(c_eb),
        .cfg_interlace(c_int), .cfg_odd_first(c_oddf), .cfg_half_extra(c_ext),
        .hsync(hsync), .vsync(vsync), .active_video(active_video), .field_id(field_id),
        .pix_x(pix_x), .line_y(line_y)
    );

    int checks = 0;
    int errors = 0;
    int m [15];
    int k;
    int last_k;
    bit dirty;
    bit done = 0;
    int unused_seed;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d (k=%0d)", req, what, act, exp, k);
        end
    endtask

    function automatic int cur_cfg(input int i);
        case (i)
            0: return int'(c_ha);   1: return int'(c_hf);   2: return int'(c_hs);   3: return int'(c_hb);
            4: return int'(c_oa);   5: return int'(c_of);   6: return int'(c_os);   7: return int'(c_ob);
            8: return int'(c_ea);   9: return int'(c_ef);  10: return int'(c_es);  11: return int'(c_eb);
            12: return int'(c_int); 13: return int'(c_oddf); default: return int'(c_ext);
        endcase
    endfunction

    task automatic snapshot();
        for (int i = 0; i < 15; i++) m[i] = cur_cfg(i);
    endtask

    function automatic bit differs();
        for (int i = 0; i < 15; i++) if (m[i] != cur_cfg(i)) return 1'b1;
        return 1'b0;
    endfunction

    // R4: segment lengths of a field including the extra line
    function automatic void flens(input int fid, output int a, output int f, output int s, output int b);
        if (fid == 1) begin
            a = m[4]; f = m[5]; s = m[6]; b = m[7] + ((m[12] == 1 && m[13] == 0) ? 1 : 0);
        end else begin
            a = m[8]; f = m[9] + ((m[12] == 1 && m[13] == 1) ? 1 : 0); s = m[10]; b = m[11];
        end
    endfunction

    function automatic int vreg(input int ly, input int a, input int f, input int s);
        if (ly < a) return 0;
        if (ly < a + f) return 1;
        if (ly < a + f + s) return 2;
        return 3;
    endfunction

    task automatic check_cycle();
        int htot, first, second, a, f, s, b, l1, l2, line, p, fid, ly, d, e_vs;
        bit shifted;
        htot   = m[0] + m[1] + m[2] + m[3];
        first  = (m[12] == 1) ? m[13] : 1;
        second = 1 - first;
        flens(first, a, f, s, b);  l1 = a + f + s + b;
        if (m[12] == 1) begin flens(second, a, f, s, b); l2 = a + f + s + b; end
        else l2 = 0;
        last_k = (l1 + l2) * htot - 1;
        line = k / htot;
        p    = k % htot;
        if (line < l1) begin fid = first;  ly = line;      shifted = 0; end
        else           begin fid = second; ly = line - l1; shifted = 1; end
        flens(fid, a, f, s, b);
        chk("R1", "pix_x", int'(pix_x), p);
        chk("R1", "hsync", int'(hsync), (p >= m[0] + m[1] && p < m[0] + m[1] + m[2]) ? 1 : 0);
        chk("R2", "line_y", int'(line_y), ly);
        chk("R3", "active_video", int'(active_video), (p < m[0] && ly < a) ? 1 : 0);
        chk("R5", "field_id", int'(field_id), fid);
        if (!shifted) e_vs = (vreg(ly, a, f, s) == 2) ? 1 : 0;
        else begin
            d = htot / 2 + m[14];
            if (p >= d) e_vs = (vreg(ly, a, f, s) == 2) ? 1 : 0;
            else        e_vs = (ly > 0 && vreg(ly - 1, a, f, s) == 2) ? 1 : 0;
        end
        chk("R6", "vsync", int'(vsync), e_vs);
        if (m[12] == 1 && p == htot - 1 && ly == a + f + s + b - 1)
            chk("R4", "field_last_line", int'(line_y), a + f + s + b - 1);
        if (dirty) chk("R7", "pix_x_after_midframe_change", int'(pix_x), p);
    endtask

    task automatic rand_cfg();
        c_ha = HW'(4 + $urandom % 9);  c_hf = HW'(1 + $urandom % 4);
        c_hs = HW'(1 + $urandom % 4);  c_hb = HW'(1 + $urandom % 4);
        c_oa = VW'(2 + $urandom % 5);  c_of = VW'(1 + $urandom % 3);
        c_os = VW'(1 + $urandom % 3);  c_ob = VW'(1 + $urandom % 3);
        c_ea = VW'(2 + $urandom % 5);  c_ef = VW'(1 + $urandom % 3);
        c_es = VW'(1 + $urandom % 3);  c_eb = VW'(1 + $urandom % 3);
        c_int = 1'($urandom % 4 != 0);
        c_oddf = 1'($urandom % 2);
        c_ext = 1'($urandom % 2);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired before the run completed");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        unused_seed = $urandom(32'd7319);
        for (int ph = 0; ph < 14; ph++) begin
            rand_cfg();
            case (ph)
                0: begin c_int = 1; c_oddf = 1; c_ext = 1; end  // odd first, like 525 lines
                1: begin c_int = 1; c_oddf = 0; c_ext = 1; end  // even first, like 625 lines
                2: begin c_int = 0; end                         // progressive
                3: begin c_int = 1; c_oddf = 1; c_ext = 0; end
                default: ;
            endcase
            rst_n = 1'b0;
            repeat (3) @(posedge clk);
            @(negedge clk);
            // R8: reset state
            chk("R8", "reset pix_x", int'(pix_x), 0);
            chk("R8", "reset line_y", int'(line_y), 0);
            chk("R8", "reset hsync", int'(hsync), 0);
            chk("R8", "reset vsync", int'(vsync), 0);
            chk("R8", "reset field_id", int'(field_id), c_int ? int'(c_oddf) : 1);
            snapshot();
            rst_n = 1'b1;
            k = 0;
            dirty = 0;
            for (int cyc = 0; cyc < 2000; cyc++) begin
                check_cycle();
                if (ph % 2 == 1 && k == last_k) rand_cfg();          // change exactly at frame end
                else if (ph >= 4 && $urandom % 40 == 0) rand_cfg();  // change mid-frame
                if (k == last_k) begin
                    snapshot();
                    k = 0;
                end else begin
                    k++;
                end
                dirty = differs();
                @(negedge clk);
            end
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule